// File: doc/BRIEF.md
# Windowed Running-Sum Limit-Cycle Detector

This block watches the one-bit output stream of a first-order delta-sigma modulator while a slow linear ramp drives its input, and it locates the stretch of the ramp over which the modulator settles into the repeating 011 pattern. Every incoming bit is turned into +1 (for a one) or -1 (for a zero), whatever analog levels the quantizer really produces. A sliding window of the most recent N mapped bits is summed. A window whose sum equals N/3 carries the 011 signature.

Software arms the block with a start pulse. The pulse sets the window length N, which must be a multiple of 3 between 3 and 48, and sets the minimum number of consecutive matching windows that count as a real interval. Samples then arrive with a valid strobe and a sample index, and the final sample is flagged. The block keeps the longest qualifying run of matching windows. It reports that run as the first and last window indices and raises a done flag. A window is identified by the index of its oldest sample, so the window whose sum spans samples n to n+N-1 has index n.

Top module: `lc_window_detector`

## Requirements
- R1: A sample with bit_i = 1 adds +1 to the window sum and a sample with bit_i = 0 adds -1. The sum always covers exactly the N most recent accepted samples, so it has the parity of N and lies within -N..+N.
- R2: The first N-1 valid samples after a start produce no window. Each later valid sample forms the window whose index is idx_i - N + 1, taken modulo 2^IDX_W. Sample indices are expected to step by one per valid sample.
- R3: A window matches when its sum is exactly N/3. For example, the sum is +1 for N = 3 and +2 for N = 6.
- R4: A run of consecutive matching windows qualifies only when its length is at least min_run_i, and a min_run_i of 0 acts as 1. If no run qualifies, found_o stays 0.
- R5: For the kept run, lo_idx_o is the index of its first matching window and hi_idx_o is the index of its last matching window before the sum leaves N/3.
- R6: Among qualifying runs, the longest is kept. When two runs have equal length, the earlier one is kept.
- R7: The outputs reflect a sample two clock edges after the edge that accepts it. done_o rises two edges after the sample that carries last_i and stays high until the next start.
- R8: A start with N not a multiple of 3, or with N outside 3..48, sets cfg_err_o. While cfg_err_o is set, samples form no windows, found_o stays 0, and done_o still follows last_i.
- R9: start_i clears the window history, the run state, found_o and done_o, and it captures win_len_i and min_run_i.
- R10: After reset all outputs are 0, N is 3 and the minimum run length is 1.
- R11: A run that is still matching when the last sample arrives is closed, and that last window is included in it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Arms a new search and captures the configuration |
| win_len_i | input | NLEN_W (6) | Window length N |
| min_run_i | input | RUN_W (8) | Minimum consecutive matching windows |
| valid_i | input | 1 | Sample strobe |
| bit_i | input | 1 | Modulator output bit |
| idx_i | input | IDX_W (16) | Sample index |
| last_i | input | 1 | Marks the final sample (qualified by valid_i) |
| lo_idx_o | output | IDX_W (16) | First window index of the kept interval |
| hi_idx_o | output | IDX_W (16) | Last window index of the kept interval |
| found_o | output | 1 | A qualifying interval has been kept |
| done_o | output | 1 | The last sample has been processed |
| cfg_err_o | output | 1 | The captured window length is invalid |

## Verification
The assertions check several things on every cycle. The error flag must follow the legality of the captured window length. A bad length must never produce a window. Every window sum must keep the parity of N and stay within ±N. done_o must hold until the next start, and a start must clear the results. The kept run length must never shrink and never fall below the minimum. Three things can only be shown by the bench's scenarios, which compare against a behavioural model on every clock: the exact interval indices, the choice between competing runs, and the closing of a run that is still open at the last sample. The scenarios include hand-built bit patterns and a stream from an integer modulator model driven by a ramp.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  // +1 for a one, -1 for a zero
  function automatic logic signed [1:0] pm_of(input logic b);
    return b ? 2'sd1 : -2'sd1;
  endfunction
endpackage

// File: rtl/lcd_cfg.sv
module lcd_cfg #(
  parameter int MAX_N  = 48,
  parameter int RUN_W  = 8,
  parameter int NLEN_W = $clog2(MAX_N + 1),
  parameter int SUM_W  = NLEN_W + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [NLEN_W-1:0]       win_len_i,
  input  logic [RUN_W-1:0]        min_run_i,
  output logic [NLEN_W-1:0]       n_o,
  output logic [RUN_W-1:0]        min_run_o,
  output logic signed [SUM_W-1:0] target_o,
  output logic                    err_o
);
  logic bad_len;
  assign bad_len = (win_len_i % NLEN_W'(3) != '0) || (win_len_i < NLEN_W'(3)) ||
                   (win_len_i > NLEN_W'(MAX_N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      n_o       <= NLEN_W'(3);
      min_run_o <= RUN_W'(1);
      err_o     <= 1'b0;
    end else if (start_i) begin
      n_o       <= win_len_i;
      min_run_o <= min_run_i;
      err_o     <= bad_len;
    end
  end

  assign target_o = $signed({{(SUM_W - NLEN_W){1'b0}}, n_o / NLEN_W'(3)});
endmodule

// File: rtl/lcd_window_sum.sv
module lcd_window_sum
  import lcd_pkg::*;
#(
  parameter int MAX_N  = 48,
  parameter int IDX_W  = 16,
  parameter int NLEN_W = $clog2(MAX_N + 1),
  parameter int SUM_W  = NLEN_W + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    valid_i,
  input  logic                    bit_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic                    last_i,
  input  logic [NLEN_W-1:0]       n_i,
  input  logic                    err_i,
  output logic                    step_o,
  output logic                    win_ok_o,
  output logic                    last_o,
  output logic signed [SUM_W-1:0] sum_o,
  output logic [IDX_W-1:0]        label_o
);
  logic [MAX_N-1:0]        hist_q;
  logic [NLEN_W-1:0]       fill_q;
  logic signed [SUM_W-1:0] sum_nxt, add_v, sub_v;
  logic                    leave_bit, full;

  assign full      = (fill_q == n_i);
  assign leave_bit = hist_q[n_i - NLEN_W'(1)];

  always_comb begin
    add_v   = SUM_W'(pm_of(bit_i));
    sub_v   = full ? SUM_W'(pm_of(leave_bit)) : '0;
    sum_nxt = sum_o + add_v - sub_v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q   <= '0;
      fill_q   <= '0;
      sum_o    <= '0;
      step_o   <= 1'b0;
      win_ok_o <= 1'b0;
      last_o   <= 1'b0;
      label_o  <= '0;
    end else if (start_i) begin
      hist_q   <= '0;
      fill_q   <= '0;
      sum_o    <= '0;
      step_o   <= 1'b0;
      win_ok_o <= 1'b0;
      last_o   <= 1'b0;
    end else begin
      step_o <= valid_i;
      last_o <= valid_i & last_i;
      if (valid_i && !err_i) begin
        hist_q   <= {hist_q[MAX_N-2:0], bit_i};
        sum_o    <= sum_nxt;
        if (!full) fill_q <= fill_q + NLEN_W'(1);
        win_ok_o <= (fill_q + NLEN_W'(1)) >= n_i;
        label_o  <= idx_i - IDX_W'(n_i) + IDX_W'(1);
      end else begin
        win_ok_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/lcd_run_tracker.sv
module lcd_run_tracker #(
  parameter int IDX_W = 16,
  parameter int RUN_W = 8,
  parameter int SUM_W = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    step_i,
  input  logic                    win_ok_i,
  input  logic                    last_i,
  input  logic signed [SUM_W-1:0] sum_i,
  input  logic [IDX_W-1:0]        label_i,
  input  logic signed [SUM_W-1:0] target_i,
  input  logic [RUN_W-1:0]        min_run_i,
  output logic [IDX_W-1:0]        lo_o,
  output logic [IDX_W-1:0]        hi_o,
  output logic [IDX_W-1:0]        best_len_o,
  output logic                    done_o
);
  localparam logic [IDX_W-1:0] LEN_MAX = '1;

  logic [IDX_W-1:0] run_len_q, run_lo_q, run_hi_q;
  logic [IDX_W-1:0] eff_len, eff_lo, eff_hi, need_len;
  logic             match, close, take;

  always_comb begin
    match    = step_i && win_ok_i && (sum_i == target_i);
    eff_len  = run_len_q;
    eff_lo   = run_lo_q;
    eff_hi   = run_hi_q;
    if (match) begin
      if (run_len_q != LEN_MAX) eff_len = run_len_q + IDX_W'(1);
      if (run_len_q == '0) eff_lo = label_i;
      eff_hi = label_i;
    end
    close    = step_i && ((win_ok_i && !match) || last_i);
    need_len = (min_run_i == '0) ? IDX_W'(1) : IDX_W'(min_run_i);
    // strict compare keeps the earlier run on a tie
    take     = close && (eff_len != '0) && (eff_len >= need_len) && (eff_len > best_len_o);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_len_q  <= '0;
      run_lo_q   <= '0;
      run_hi_q   <= '0;
      best_len_o <= '0;
      lo_o       <= '0;
      hi_o       <= '0;
      done_o     <= 1'b0;
    end else if (start_i) begin
      run_len_q  <= '0;
      best_len_o <= '0;
      lo_o       <= '0;
      hi_o       <= '0;
      done_o     <= 1'b0;
    end else if (step_i) begin
      if (close) run_len_q <= '0;
      else if (match) begin
        run_len_q <= eff_len;
        run_lo_q  <= eff_lo;
        run_hi_q  <= eff_hi;
      end
      if (take) begin
        best_len_o <= eff_len;
        lo_o       <= eff_lo;
        hi_o       <= eff_hi;
      end
      if (last_i) done_o <= 1'b1;
    end
  end
endmodule

// File: rtl/lc_window_detector.sv
module lc_window_detector #(
  parameter int MAX_N  = 48,
  parameter int IDX_W  = 16,
  parameter int RUN_W  = 8,
  parameter int NLEN_W = $clog2(MAX_N + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [NLEN_W-1:0] win_len_i,
  input  logic [RUN_W-1:0]  min_run_i,
  input  logic              valid_i,
  input  logic              bit_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              last_i,
  output logic [IDX_W-1:0]  lo_idx_o,
  output logic [IDX_W-1:0]  hi_idx_o,
  output logic              found_o,
  output logic              done_o,
  output logic              cfg_err_o
);
  localparam int SUM_W = NLEN_W + 2;

  logic [NLEN_W-1:0]       n_q;
  logic [RUN_W-1:0]        min_run_q;
  logic signed [SUM_W-1:0] target, win_sum;
  logic                    step, win_ok, step_last;
  logic [IDX_W-1:0]        label, best_len;

  lcd_cfg #(.MAX_N(MAX_N), .RUN_W(RUN_W), .NLEN_W(NLEN_W), .SUM_W(SUM_W)) u_cfg (
    .clk_i, .rst_ni, .start_i, .win_len_i, .min_run_i,
    .n_o(n_q), .min_run_o(min_run_q), .target_o(target), .err_o(cfg_err_o)
  );

  lcd_window_sum #(.MAX_N(MAX_N), .IDX_W(IDX_W), .NLEN_W(NLEN_W), .SUM_W(SUM_W)) u_win (
    .clk_i, .rst_ni, .start_i, .valid_i, .bit_i, .idx_i, .last_i,
    .n_i(n_q), .err_i(cfg_err_o),
    .step_o(step), .win_ok_o(win_ok), .last_o(step_last), .sum_o(win_sum), .label_o(label)
  );

  lcd_run_tracker #(.IDX_W(IDX_W), .RUN_W(RUN_W), .SUM_W(SUM_W)) u_run (
    .clk_i, .rst_ni, .start_i,
    .step_i(step), .win_ok_i(win_ok), .last_i(step_last), .sum_i(win_sum), .label_i(label),
    .target_i(target), .min_run_i(min_run_q),
    .lo_o(lo_idx_o), .hi_o(hi_idx_o), .best_len_o(best_len), .done_o(done_o)
  );

  assign found_o = (best_len != '0);
endmodule

// File: rtl/lcd_chk.sv
module lcd_chk #(
  parameter int MAX_N  = 48,
  parameter int IDX_W  = 16,
  parameter int RUN_W  = 8,
  parameter int NLEN_W = $clog2(MAX_N + 1),
  parameter int SUM_W  = NLEN_W + 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic [NLEN_W-1:0]       win_len_i,
  input logic                    found_o,
  input logic                    done_o,
  input logic                    cfg_err_o,
  input logic                    step,
  input logic                    win_ok,
  input logic signed [SUM_W-1:0] win_sum,
  input logic [NLEN_W-1:0]       n_q,
  input logic [RUN_W-1:0]        min_run_q,
  input logic [IDX_W-1:0]        best_len
);
  logic                    bad_in;
  logic signed [SUM_W-1:0] n_s;
  logic [IDX_W-1:0]        need;
  assign bad_in = (win_len_i % NLEN_W'(3) != '0) || (win_len_i < NLEN_W'(3)) ||
                  (win_len_i > NLEN_W'(MAX_N));
  assign n_s    = $signed({{(SUM_W - NLEN_W){1'b0}}, n_q});
  assign need   = (min_run_q == '0) ? IDX_W'(1) : IDX_W'(min_run_q);

  // R8
  cfg_err_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (cfg_err_o == $past(bad_in)));
  // R8
  err_no_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_err_o |-> !(step && win_ok));
  // R1
  sum_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && win_ok) |-> ((win_sum[0] == n_q[0]) && (win_sum <= n_s) && (win_sum >= -n_s)));
  // R7
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o);
  // R9
  start_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!found_o && !done_o));
  // R4
  best_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    found_o |-> (best_len >= need));
  // R6
  best_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> (best_len >= $past(best_len)));
endmodule

bind lc_window_detector lcd_chk #(
  .MAX_N(MAX_N), .IDX_W(IDX_W), .RUN_W(RUN_W), .NLEN_W(NLEN_W), .SUM_W(NLEN_W + 2)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .win_len_i(win_len_i),
  .found_o(found_o), .done_o(done_o), .cfg_err_o(cfg_err_o),
  .step(step), .win_ok(win_ok), .win_sum(win_sum), .n_q(n_q),
  .min_run_q(min_run_q), .best_len(best_len)
);

// File: tb/lc_window_detector_tb.sv
`timescale 1ns/1ps
module lc_window_detector_tb;
  localparam int MAX_N = 48, IDX_W = 16, RUN_W = 8, NLEN_W = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, valid = 0, bit_v = 0, last = 0;
  logic [NLEN_W-1:0] win_len = 6'd3;
  logic [RUN_W-1:0]  min_run = 8'd1;
  logic [IDX_W-1:0]  idx = '0;
  logic [IDX_W-1:0]  lo_idx, hi_idx;
  logic found, done, cfg_err;

  always #2.5 clk = ~clk;

  lc_window_detector #(.MAX_N(MAX_N), .IDX_W(IDX_W), .RUN_W(RUN_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .win_len_i(win_len), .min_run_i(min_run),
    .valid_i(valid), .bit_i(bit_v), .idx_i(idx), .last_i(last),
    .lo_idx_o(lo_idx), .hi_idx_o(hi_idx), .found_o(found), .done_o(done), .cfg_err_o(cfg_err)
  );

  int n_cmp = 0, n_bad = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural reference
  int q[$];
  int m_n = 3, m_min = 1, rl = 0, best = 0;
  bit m_err = 0, e_done = 0;
  bit p_vld = 0, p_win = 0, p_last = 0;
  int p_sum = 0;
  logic [IDX_W-1:0] p_label = '0, rlo = '0, rhi = '0, e_lo = '0, e_hi = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_n = 3; m_min = 1; m_err = 0; rl = 0; best = 0;
      e_done = 0; e_lo = '0; e_hi = '0; p_vld = 0;
    end else begin
      if (p_vld) begin
        bit match, close;
        int need;
        match = p_win && (p_sum == m_n / 3);
        if (match) begin
          if (rl == 0) rlo = p_label;
          rl++;
          rhi = p_label;
        end
        close = (p_win && !match) || p_last;
        need = (m_min == 0) ? 1 : m_min;
        if (close) begin
          if (rl > 0 && rl >= need && rl > best) begin
            best = rl; e_lo = rlo; e_hi = rhi;
          end
          rl = 0;
        end
        if (p_last) e_done = 1;
      end
      if (start) begin
        q.delete();
        m_n = int'(win_len); m_min = int'(min_run);
        m_err = (m_n % 3 != 0) || m_n < 3 || m_n > MAX_N;
        rl = 0; best = 0; e_done = 0; e_lo = '0; e_hi = '0; p_vld = 0;
      end else begin
        p_vld = valid;
        p_last = valid && last;
        p_win = 0;
        if (valid && !m_err) begin
          int s;
          q.push_back(bit_v ? 1 : -1);
          if (q.size() > m_n) void'(q.pop_front());
          p_win = (q.size() == m_n);
          s = 0;
          foreach (q[i]) s += q[i];
          p_sum = s;
          p_label = IDX_W'(int'(idx) - m_n + 1);
        end
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R7 done", int'(done), int'(e_done));
      chk("R4 found", int'(found), int'(best > 0));
      chk("R8 cfg_err", int'(cfg_err), int'(m_err));
      if (best > 0) begin
        chk("R5 lo", int'(lo_idx), int'(e_lo));
        chk("R5 hi", int'(hi_idx), int'(e_hi));
      end
    end
  end

  task automatic arm(input int n, input int mr);
    @(negedge clk);
    start = 1; win_len = NLEN_W'(n); min_run = RUN_W'(mr);
    @(negedge clk);
    start = 0; idx = '0;
  endtask

  task automatic send(input bit b, input bit l);
    @(negedge clk);
    valid = 1; bit_v = b; last = l;
    @(negedge clk);
    valid = 0; last = 0;
    idx = idx + 1'b1;
  endtask

  // back-to-back stream of bits given as a string of '0'/'1'
  task automatic stream(input string s);
    for (int i = 0; i < s.len(); i++) begin
      @(negedge clk);
      valid = 1; bit_v = (s[i] == "1"); last = (i == s.len() - 1);
      if (i > 0) idx = idx + 1'b1;
    end
    @(negedge clk);
    valid = 0; last = 0; idx = idx + 1'b1;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  // integer first-order modulator driven by a ramp (full scale 1024)
  task automatic mod_ramp(input int x0, input int x1, input int hold);
    int u = 0;
    for (int x = x0; x <= x1; x++) begin
      for (int h = 0; h < hold; h++) begin
        bit qb = (u >= 0);
        @(negedge clk);
        valid = 1; bit_v = qb; last = (x == x1) && (h == hold - 1);
        if (!(x == x0 && h == 0)) idx = idx + 1'b1;
        u = u + x - (qb ? 1024 : -1024);
      end
    end
    @(negedge clk);
    valid = 0; last = 0; idx = idx + 1'b1;
  endtask

  bit finished = 0;

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 lo", int'(lo_idx), 0);
    chk("R10 hi", int'(hi_idx), 0);
    chk("R10 found", int'(found), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 cfg_err", int'(cfg_err), 0);
    rst_n = 1;
    @(negedge clk);

    // R1 R3 R5: N=3, windows 2..6 sum to +1
    arm(3, 1);
    stream("00011011000");
    settle();
    chk("R3 found", int'(found), 1);
    chk("R5 lo", int'(lo_idx), 2);
    chk("R5 hi", int'(hi_idx), 6);
    chk("R7 done", int'(done), 1);

    // R9 start clears results
    arm(3, 1);
    chk("R9 found cleared", int'(found), 0);
    chk("R9 done cleared", int'(done), 0);
    // R4 run of 5 rejected with min 9
    arm(3, 9);
    stream("00011011000");
    settle();
    chk("R4 short run rejected", int'(found), 0);
    chk("R4 done", int'(done), 1);

    // R11 run still open at last sample
    arm(3, 0);
    stream("00011011");
    settle();
    chk("R11 lo", int'(lo_idx), 2);
    chk("R11 hi", int'(hi_idx), 5);

    // R6 tie keeps earlier: two runs of 3 windows each
    arm(3, 1);
    stream("0000110100000011010000");
    settle();
    chk("R6 tie lo", int'(lo_idx), 3);
    chk("R6 tie hi", int'(hi_idx), 5);
    // R6 longer second run wins
    arm(3, 1);
    stream("00001101000000110110100000");
    settle();
    chk("R6 longest lo", int'(lo_idx), 13);
    chk("R6 longest hi", int'(hi_idx), 18);

    // R2 fewer than N samples: no window
    arm(6, 1);
    stream("01101");
    settle();
    chk("R2 no window", int'(found), 0);
    chk("R2 done", int'(done), 1);
    // R2 R3 N=6 level +2, first window index 0
    arm(6, 1);
    stream("011011011000000");
    settle();
    chk("R2 first label", int'(lo_idx), 0);
    chk("R3 N6 hi", int'(hi_idx), 4);

    // R8 invalid lengths
    arm(7, 1);
    stream("011011011011");
    settle();
    chk("R8 err N7", int'(cfg_err), 1);
    chk("R8 no result", int'(found), 0);
    chk("R8 done", int'(done), 1);
    arm(51, 1);
    chk("R8 err N51", int'(cfg_err), 1);
    arm(0, 1);
    chk("R8 err N0", int'(cfg_err), 1);
    arm(48, 1);
    chk("R8 N48 legal", int'(cfg_err), 0);

    // R1 R5 ramp-driven modulator streams, checked against the model every clock
    arm(6, 4);
    mod_ramp(-200, 700, 1);
    settle();
    chk("R5 ramp N6 done", int'(done), 1);
    arm(48, 3);
    mod_ramp(200, 500, 8);
    settle();
    chk("R1 ramp N48 found", int'(found), int'(best > 0));
    send(1'b0, 1'b1);
    settle();

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule